// File: doc/BRIEF.md
# Preloadable 16-bit Timer/Event Counter

This block is a 16-bit up-counter with a separate 16-bit reload value. A processor reaches it over an 8-bit register bus. A control register chooses what advances the counter. The choices are every system clock, every fourth system clock, an RTC strobe, rising edges of an A/D oscillator clock, active edges of an external event pin, or system clock/4 ticks gated by the level of the event pin (pulse-width measurement). The control register also carries a run bit and an edge-polarity bit.

When the counter steps past 0xFFFF it takes the reload value, raises a one-cycle overflow flag and toggles a square-wave output. The 16-bit values cross the 8-bit bus in byte halves. A low byte written to the bus waits in a holding buffer until the high byte is written, and then both halves land together. Reading the counter high byte freezes the low byte for a later read. While the counter runs, its byte registers and the reload byte registers are locked.

Top module: `tmr16_ctr`

## Requirements
- R1: After a synchronous reset, every register reads 0x00, `ovf_irq` is 0 and `pfd_out` is 0.
- R2: The control register is at BASE+0: bits 7:5 hold the source code, bit 4 holds run, bit 3 holds edge polarity, and bits 2:0 read as 0. Read data appears on `bus_rdata` in the cycle after the read strobe and is 0x00 in any cycle without a read.
- R3: The function register is at BASE+1 and only bit 1 is stored (it reads back in bit 1, other bits read 0). When bit 1 is 1, the counter does not advance even while run is 1.
- R4: Source codes select what advances the counter: 000 every cycle, 001 once every four cycles from a free-running divider, 010 each cycle with `rtc_tick` high, 011 each rising edge of `adc_clk`, 100 each active edge of `evt_pin`. Codes 110 and 111 never advance it. `adc_clk` and `evt_pin` pass through a two-flop synchronizer, so an edge is counted at the third rising clock edge after the pin changes.
- R5: With polarity 0 the active event edge is rising, and with polarity 1 it is falling.
- R6: Code 101 advances the counter on divider ticks while `evt_pin` is at its active level (high for polarity 0, low for polarity 1). When the pin leaves the active level, run clears by itself, unless the control register is written in that same cycle, in which case the write wins.
- R7: A write to the reload low byte (BASE+5) changes only the holding buffer. A write to the reload high byte (BASE+4) loads {written byte, holding buffer} into the reload value in one cycle. Both reload bytes can be read back.
- R8: A write to the counter low byte (BASE+3) also fills the same holding buffer. A write to the counter high byte (BASE+2) loads {written byte, holding buffer} into the counter.
- R9: A read of the counter high byte returns bits 15:8 and copies bits 7:0 into a read snapshot. Reads of the counter low byte return that snapshot, not the live count.
- R10: While run is 1, reads and writes at BASE+2..BASE+5 have no effect on any state, and those reads return 0x00.
- R11: A count step from 0xFFFF loads the reload value, drives `ovf_irq` high for exactly that one cycle, and toggles `pfd_out`. A control write that clears run in the same cycle does not cancel that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rtc_tick | input | 1 | RTC strobe, synchronous to clk |
| adc_clk | input | 1 | A/D oscillator clock, asynchronous |
| evt_pin | input | 1 | External event / gate pin, asynchronous |
| ovf_irq | output | 1 | One-cycle overflow flag |
| pfd_out | output | 1 | Toggles on every overflow |

## Verification
Two events can land in the same clock edge: a count step from 0xFFFF and a control write that clears run. The bench provokes this by loading the counter with 0xFFFF, then issuing a run write and a stop write on consecutive cycles. It then judges the result on the overflow pulse, the `pfd_out` toggle and a counter readback that equals the reload value. The pulse-width stop has a similar hazard. Its end-of-level clear is checked by reading the control byte after the gate pulse, with every cycle compared against a behavioural reference model.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  // register offsets from the base address
  localparam int OFS_CTRL = 0;
  localparam int OFS_FSEL = 1;
  localparam int OFS_CNTH = 2;
  localparam int OFS_CNTL = 3;
  localparam int OFS_PREH = 4;
  localparam int OFS_PREL = 5;

  // control-register bit positions (software decodes these)
  localparam int CB_SRC_LO = 5;
  localparam int CB_RUN    = 4;
  localparam int CB_EDGE   = 3;
  localparam int FB_SUSP   = 1;

  typedef enum logic [2:0] {
    SRC_SYS  = 3'd0,
    SRC_SYS4 = 3'd1,
    SRC_RTC  = 3'd2,
    SRC_ADC  = 3'd3,
    SRC_EVT  = 3'd4,
    SRC_PW   = 3'd5,
    SRC_NO6  = 3'd6,
    SRC_NO7  = 3'd7
  } src_e;
endpackage

// File: rtl/tmr16_sync.sv
module tmr16_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] q_d
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      q_d   <= '0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      q_d   <= chain[STAGES-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tmr16_tick.sv
module tmr16_tick
  import tmr16_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  src_e mode,
  input  logic edge_fall,
  input  logic rtc_tick,
  input  logic adc_q,
  input  logic adc_qd,
  input  logic evt_q,
  input  logic evt_qd,
  output logic tick,
  output logic pw_end
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pre;
  logic          pre_hit;
  logic          act_now, act_prev;

  assign pre_hit = (pre == PW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)          pre <= '0;
    else if (pre_hit) pre <= '0;
    else              pre <= pre + 1'b1;
  end

  assign act_now  = evt_q  ^ edge_fall;
  assign act_prev = evt_qd ^ edge_fall;

  always_comb begin
    tick   = 1'b0;
    pw_end = 1'b0;
    case (mode)
      SRC_SYS:  tick = 1'b1;
      SRC_SYS4: tick = pre_hit;
      SRC_RTC:  tick = rtc_tick;
      SRC_ADC:  tick = adc_q & ~adc_qd;
      SRC_EVT:  tick = act_now & ~act_prev;
      SRC_PW: begin
        tick   = pre_hit & act_now;
        pw_end = act_prev & ~act_now;
      end
      default: ;
    endcase
  end

  // R4
  pre_gap_chk: assert property (@(posedge clk) disable iff (rst)
    pre_hit |=> !pre_hit);
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cnt_en,
  input  logic            wr_lo_buf,
  input  logic            wr_cnt_hi,
  input  logic            wr_pre_hi,
  input  logic            rd_cnt_hi,
  input  logic [BW-1:0]   wdata,
  output logic [2*BW-1:0] cnt,
  output logic [2*BW-1:0] preload,
  output logic [BW-1:0]   rd_lo,
  output logic            ovf,
  output logic            pfd
);
  localparam int CW = 2 * BW;

  logic [BW-1:0] wbuf;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      preload <= '0;
      wbuf    <= '0;
      rd_lo   <= '0;
      ovf     <= 1'b0;
      pfd     <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (cnt_en) begin
        if (cnt == {CW{1'b1}}) begin
          cnt <= preload;
          ovf <= 1'b1;
          pfd <= ~pfd;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (wr_cnt_hi) begin
        cnt <= {wdata, wbuf};
      end
      if (wr_lo_buf) wbuf    <= wdata;
      if (wr_pre_hi) preload <= {wdata, wbuf};
      if (rd_cnt_hi) rd_lo   <= cnt[BW-1:0];
    end
  end

  // R11
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |-> cnt == $past(preload));
  // R11
  pfd_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |-> pfd != $past(pfd));
  // R11
  pfd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ovf |-> $stable(pfd));
  // R4
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && cnt != {CW{1'b1}}) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/tmr16_ctr.sv
module tmr16_ctr
  import tmr16_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int ADDR_W      = 8,
  parameter int BASE        = 'h20,
  parameter int PRE_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              rtc_tick,
  input  logic              adc_clk,
  input  logic              evt_pin,
  output logic              ovf_irq,
  output logic              pfd_out
);
  localparam int CW = 2 * BUS_W;

  logic [2:0] src_q;
  logic       run_q, edge_q, susp_q;

  logic sel_ctrl, sel_fsel, sel_cnth, sel_cntl, sel_preh, sel_prel, sel_lock;
  assign sel_ctrl = bus_addr == ADDR_W'(BASE + OFS_CTRL);
  assign sel_fsel = bus_addr == ADDR_W'(BASE + OFS_FSEL);
  assign sel_cnth = bus_addr == ADDR_W'(BASE + OFS_CNTH);
  assign sel_cntl = bus_addr == ADDR_W'(BASE + OFS_CNTL);
  assign sel_preh = bus_addr == ADDR_W'(BASE + OFS_PREH);
  assign sel_prel = bus_addr == ADDR_W'(BASE + OFS_PREL);
  assign sel_lock = sel_cnth | sel_cntl | sel_preh | sel_prel;

  logic [1:0] sq, sqd;
  tmr16_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .din ({adc_clk, evt_pin}), .q (sq), .q_d (sqd)
  );

  logic tick, pw_end;
  tmr16_tick #(.DIV(PRE_DIV)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .mode     (src_e'(src_q)),
    .edge_fall(edge_q),
    .rtc_tick (rtc_tick),
    .adc_q    (sq[1]),
    .adc_qd   (sqd[1]),
    .evt_q    (sq[0]),
    .evt_qd   (sqd[0]),
    .tick     (tick),
    .pw_end   (pw_end)
  );

  logic ctrl_wr;
  assign ctrl_wr = bus_wr & sel_ctrl;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      run_q  <= 1'b0;
      edge_q <= 1'b0;
      susp_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        src_q  <= bus_wdata[CB_SRC_LO +: 3];
        run_q  <= bus_wdata[CB_RUN];
        edge_q <= bus_wdata[CB_EDGE];
      end else if (pw_end && run_q) begin
        run_q <= 1'b0;
      end
      if (bus_wr && sel_fsel) susp_q <= bus_wdata[FB_SUSP];
    end
  end

  logic [CW-1:0]    cnt, preload;
  logic [BUS_W-1:0] rd_lo;
  tmr16_core #(.BW(BUS_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .cnt_en    (run_q & ~susp_q & tick),
    .wr_lo_buf (bus_wr & ~run_q & (sel_cntl | sel_prel)),
    .wr_cnt_hi (bus_wr & ~run_q & sel_cnth),
    .wr_pre_hi (bus_wr & ~run_q & sel_preh),
    .rd_cnt_hi (bus_rd & ~run_q & sel_cnth),
    .wdata     (bus_wdata),
    .cnt       (cnt),
    .preload   (preload),
    .rd_lo     (rd_lo),
    .ovf       (ovf_irq),
    .pfd       (pfd_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      if (bus_rd) begin
        if (sel_ctrl)
          bus_rdata <= BUS_W'({src_q, run_q, edge_q, 3'b000});
        else if (sel_fsel)
          bus_rdata <= BUS_W'({susp_q, 1'b0});
        else if (!run_q) begin
          if (sel_cnth)      bus_rdata <= cnt[CW-1:BUS_W];
          else if (sel_cntl) bus_rdata <= rd_lo;
          else if (sel_preh) bus_rdata <= preload[CW-1:BUS_W];
          else if (sel_prel) bus_rdata <= preload[BUS_W-1:0];
        end
      end
    end
  end

  // R10
  lock_pre_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && bus_wr) |=> $stable(preload));
  // R10
  lock_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && bus_rd && sel_lock) |=> bus_rdata == '0);
  // R2
  ctrl_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel_ctrl) |=> bus_rdata[2:0] == 3'b000);
  // R6
  pw_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (pw_end && run_q && !ctrl_wr) |=> !run_q);
endmodule

// File: tb/tmr16_ctr_bench.sv
module tmr16_ctr_bench;
  localparam logic [7:0] A_CTRL = 8'h20, A_FSEL = 8'h21, A_CNTH = 8'h22,
                         A_CNTL = 8'h23, A_PREH = 8'h24, A_PREL = 8'h25;

  logic       clk = 1'b0, rst = 1'b1;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic       rtc_tick = 1'b0, adc_clk = 1'b0, evt_pin = 1'b0;
  logic [7:0] bus_rdata;
  logic       ovf_irq, pfd_out;

  always #4 clk = ~clk;

  tmr16_ctr u_tmr16_ctr (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rtc_tick(rtc_tick),
    .adc_clk(adc_clk), .evt_pin(evt_pin), .ovf_irq(ovf_irq), .pfd_out(pfd_out)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;

  // ---------------- behavioural reference model ----------------
  int m_cnt, m_pre, m_wbuf, m_rbuf, m_div, m_mode, m_rd;
  bit m_ton, m_te, m_fsel, m_ovf, m_pfd;
  bit evq[$], adq[$];
  int n_cnt, n_rd, off;
  bit n_ton, n_ovf, n_pfd, tk, a_now, a_prev, pwe;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_pre = 0; m_wbuf = 0; m_rbuf = 0; m_div = 0; m_mode = 0;
      m_rd = 0; m_ton = 0; m_te = 0; m_fsel = 0; m_ovf = 0; m_pfd = 0;
      evq = '{0, 0, 0}; adq = '{0, 0, 0};
    end else begin
      a_now  = evq[1] ^ m_te;
      a_prev = evq[2] ^ m_te;
      pwe = 0;
      case (m_mode)
        0: tk = 1;
        1: tk = (m_div == 3);
        2: tk = rtc_tick;
        3: tk = adq[1] && !adq[2];
        4: tk = a_now && !a_prev;
        5: begin tk = (m_div == 3) && a_now; pwe = a_prev && !a_now; end
        default: tk = 0;
      endcase
      n_cnt = m_cnt; n_ovf = 0; n_pfd = m_pfd; n_ton = m_ton;
      if (m_ton && !m_fsel && tk) begin
        if (m_cnt == 65535) begin n_cnt = m_pre; n_ovf = 1; n_pfd = !m_pfd; end
        else n_cnt = m_cnt + 1;
      end
      n_rd = 0;
      off = int'(bus_addr) - 'h20;
      if (bus_rd) begin
        case (off)
          0: n_rd = (m_mode << 5) | (int'(m_ton) << 4) | (int'(m_te) << 3);
          1: n_rd = int'(m_fsel) << 1;
          2: if (!m_ton) begin n_rd = m_cnt >> 8; m_rbuf = m_cnt & 255; end
          3: if (!m_ton) n_rd = m_rbuf;
          4: if (!m_ton) n_rd = m_pre >> 8;
          5: if (!m_ton) n_rd = m_pre & 255;
          default: ;
        endcase
      end
      if (bus_wr) begin
        case (off)
          0: begin m_mode = int'(bus_wdata) >> 5; n_ton = bus_wdata[4]; m_te = bus_wdata[3]; end
          1: m_fsel = bus_wdata[1];
          2: if (!m_ton) n_cnt = (int'(bus_wdata) << 8) | m_wbuf;
          3: if (!m_ton) m_wbuf = int'(bus_wdata);
          4: if (!m_ton) m_pre = (int'(bus_wdata) << 8) | m_wbuf;
          5: if (!m_ton) m_wbuf = int'(bus_wdata);
          default: ;
        endcase
      end
      if (!(bus_wr && off == 0) && pwe && m_ton) n_ton = 0;
      m_div = (m_div + 1) % 4;
      evq.push_front(evt_pin); void'(evq.pop_back());
      adq.push_front(adc_clk); void'(adq.pop_back());
      m_cnt = n_cnt; m_ovf = n_ovf; m_pfd = n_pfd; m_ton = n_ton; m_rd = n_rd;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check("cycle rdata R2", int'(bus_rdata), m_rd);
      check("cycle ovf R11", int'(ovf_irq), int'(m_ovf));
      check("cycle pfd R11", int'(pfd_out), int'(m_pfd));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output int v);
    bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; v = int'(bus_rdata);
  endtask

  task automatic setcnt(int v);
    wr(A_CNTL, 8'(v & 255)); wr(A_CNTH, 8'(v >> 8));
  endtask

  task automatic getcnt(output int v);
    int h, l;
    rd(A_CNTH, h); rd(A_CNTL, l); v = (h << 8) | l;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  int v, snap;

  initial begin
    idle(3); rst = 0; idle(1);
    // R1 reset state
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_CNTH, v); check("R1 cnth", v, 0);
    rd(A_PREH, v); check("R1 preh", v, 0);
    check("R1 pfd", int'(pfd_out), 0);
    // R2 control readback, low bits zero
    wr(A_CTRL, 8'h0F); rd(A_CTRL, v); check("R2 ctrl", v, 8'h08);
    wr(A_CTRL, 8'h00);
    // R7 buffered reload write
    wr(A_PREL, 8'h34);
    rd(A_PREH, v); check("R7 preh untouched", v, 0);
    rd(A_PREL, v); check("R7 prel untouched", v, 0);
    wr(A_PREH, 8'h12);
    rd(A_PREH, v); check("R7 preh", v, 8'h12);
    rd(A_PREL, v); check("R7 prel", v, 8'h34);
    // R8 counter write, R9 snapshot read
    setcnt(16'hFFFE);
    rd(A_CNTH, v); check("R8 cnth", v, 8'hFF);
    rd(A_CNTL, v); check("R9 cntl", v, 8'hFE);
    setcnt(16'h2211);
    rd(A_CNTL, v); check("R9 snapshot held", v, 8'hFE);
    // R11 overflow and reload
    setcnt(16'hFFFE);
    wr(A_CTRL, 8'h10);
    @(negedge clk); check("R11 no ovf yet", int'(ovf_irq), 0);
    @(negedge clk); check("R11 ovf pulse", int'(ovf_irq), 1);
    check("R11 pfd toggled", int'(pfd_out), 1);
    wr(A_CTRL, 8'h00);
    getcnt(v); check("R11 reloaded count", v, 16'h1235);
    // R10 lock while running
    wr(A_CTRL, 8'h10);
    rd(A_CNTH, v); check("R10 locked read", v, 0);
    wr(A_PREL, 8'h99); wr(A_PREH, 8'h77);
    wr(A_CTRL, 8'h00);
    rd(A_CNTL, v); check("R10 snapshot kept", v, m_rbuf);
    check("R10 snapshot value", v, 8'h35);
    rd(A_PREH, v); check("R10 preh kept", v, 8'h12);
    rd(A_PREL, v); check("R10 prel kept", v, 8'h34);
    // R4 divide by four
    setcnt(0); wr(A_CTRL, 8'h30); idle(40); wr(A_CTRL, 8'h20);
    snap = m_cnt; getcnt(v); check("R4 div4", v, snap);
    check("R4 div4 range", int'(v >= 10 && v <= 11), 1);
    // R4 RTC strobe
    setcnt(0); wr(A_CTRL, 8'h50);
    for (int i = 0; i < 5; i++) begin rtc_tick = 1; idle(1); rtc_tick = 0; idle(2); end
    wr(A_CTRL, 8'h40); getcnt(v); check("R4 rtc", v, 5);
    // R4 A/D clock rising edges
    setcnt(0); wr(A_CTRL, 8'h70);
    for (int i = 0; i < 7; i++) begin adc_clk = 1; idle(3); adc_clk = 0; idle(3); end
    idle(4); wr(A_CTRL, 8'h60); getcnt(v); check("R4 adc", v, 7);
    // R5 event edges, rising then falling
    setcnt(0); wr(A_CTRL, 8'h90);
    for (int i = 0; i < 6; i++) begin evt_pin = 1; idle(3); evt_pin = 0; idle(3); end
    idle(4); wr(A_CTRL, 8'h80); getcnt(v); check("R5 rising", v, 6);
    setcnt(0); wr(A_CTRL, 8'h98);
    for (int i = 0; i < 4; i++) begin evt_pin = 1; idle(5); evt_pin = 0; idle(2); end
    idle(4); wr(A_CTRL, 8'h88); getcnt(v); check("R5 falling", v, 4);
    // R4 unused source code
    setcnt(0); wr(A_CTRL, 8'hD0); idle(20); wr(A_CTRL, 8'hC0);
    getcnt(v); check("R4 unused code", v, 0);
    // R3 suspend via function register
    wr(A_FSEL, 8'hFF); rd(A_FSEL, v); check("R3 fsel", v, 8'h02);
    setcnt(0); wr(A_CTRL, 8'h10); idle(20); wr(A_CTRL, 8'h00);
    getcnt(v); check("R3 suspended", v, 0);
    wr(A_FSEL, 8'h00);
    // R6 pulse-width measurement
    setcnt(0); wr(A_CTRL, 8'hB0);
    evt_pin = 1; idle(40); evt_pin = 0; idle(6);
    rd(A_CTRL, v); check("R6 run cleared", v, 8'hA0);
    snap = m_cnt; getcnt(v); check("R6 width", v, snap);
    check("R6 width range", int'(v >= 9 && v <= 11), 1);
    // R11 overflow in the same cycle as a stopping control write
    setcnt(16'hFFFF);
    wr(A_CTRL, 8'h10); wr(A_CTRL, 8'h00);
    check("R11 pfd toggled back", int'(pfd_out), 0);
    getcnt(v); check("R11 same-cycle reload", v, 16'h1234);
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule